// File: doc/BRIEF.md
# Masked Vector Compress Unit

This unit packs selected elements of one vector register into the low end of a destination register. A single-cycle `start_i` pulse samples the source vector, a mask vector, the element width, the mask stride, the register-group size, the vector length, the start index and three register indices. The unit then walks the source elements in increasing index order, one per clock. Each element whose mask bit is set goes into the next free destination slot. After that, the unit fills the remaining slots of the active range with zeros, one slot per clock.

The mask is stored in a spaced layout. The enable bit of element `i` sits at bit `i * MLEN`, where MLEN is given as a power of two. The active slot range ends at the smaller of two limits: VLMAX = VLEN / MLEN, and the number of elements of the chosen width that fit in one register. Slots at or above that limit keep their old contents.

Before any work starts, the register indices and the start index are checked. A forbidden combination finishes the operation at once with an error flag set, and the destination is left untouched. A legal operation finishes with a one-cycle `done_o` and the packed count. It also asks the surrounding logic to clear its start index.

Top module: `vec_compress_unit`

## Requirements
- R1: Source elements with their mask bit set are written to destination slots 0, 1, 2, ... in increasing source-index order. No gaps are left between them.
- R2: The enable bit of element i is mask bit i*2^mlen_lg_i, where mlen_lg_i is 0 to 6. Mask bits at any other position have no effect.
- R3: Only source indices below min(vl_i, limit) are examined. Here limit = min(VLEN>>mlen_lg_i, VLEN/SEW). A vl_i above limit is clamped to limit.
- R4: Destination slots from the packed count up to limit-1 are set to zero. Slots at index limit and above keep their previous value.
- R5: sew_i codes 0, 1, 2, 3 select 8-, 16-, 32- and 64-bit elements. Slot k occupies bits [k*SEW +: SEW] of the register, in little-endian order.
- R6: The operation is illegal when rd_i equals rs2_i.
- R7: The operation is illegal when rm_i satisfies rd_i <= rm_i < rd_i + 2^lmul_i. A mask index just outside that group is legal.
- R8: The operation is illegal when vstart_i is not zero.
- R9: An illegal operation raises done_o and err_o in the cycle right after the start edge. It leaves dest_o unchanged, reports count 0 and does not raise vstart_clr_o. A legal operation raises vstart_clr_o together with done_o, with err_o low.
- R10: A legal operation takes one cycle per examined element and one cycle per zeroed slot. done_o rises one cycle after the last zero is written. The total is n + (limit - count) + 1 cycles after the start edge, where n is the number of examined elements.
- R11: count_o equals the number of packed elements and is valid while done_o is high.
- R12: Register index 0 is an ordinary destination and is not treated as an implied mask. rd_i = 0 with rm_i = 1 is legal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse; all operands sampled on this edge |
| sew_i | input | 2 | Element width code (8 << code bits) |
| mlen_lg_i | input | 3 | log2 of the mask bit stride |
| lmul_i | input | 2 | log2 of the destination group size in registers |
| vl_i | input | CNT_W | Vector length |
| vstart_i | input | CNT_W | Start index; must be zero |
| rd_i | input | 5 | Destination register index |
| rs2_i | input | 5 | Source register index |
| rm_i | input | 5 | Mask register index |
| src_i | input | VLEN | Source vector contents |
| mask_i | input | VLEN | Mask register contents |
| dest_o | output | VLEN | Destination register contents |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Illegal-operation flag, valid with done_o |
| count_o | output | CNT_W | Number of packed elements |
| vstart_clr_o | output | 1 | Request to reset the start index, with a legal done_o |

## Verification
The bench builds the unit with its default VLEN of 128 bits, which gives CNT_W of 8. With this width a 16-bit mask stride and byte elements bring VLMAX (8) below the register capacity (16), so the untouched upper slots can be observed. A unit stride lets VLMAX reach 128 while capacity caps it at 16. A vl of 200 exercises the clamp. Each element width from 8 to 64 bits gives a different slot count and therefore a different cycle count, and the bench predicts both.

// File: rtl/vcu_pkg.sv
package vcu_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_TAIL} vcu_state_e;
  localparam int unsigned REG_IDX_W = 5;
  localparam int unsigned ELEM_MAX_W = 64;
endpackage

// File: rtl/vcu_check.sv
module vcu_check #(
  parameter int unsigned VLEN = 128,
  parameter int unsigned CW   = 8
) (
  input  logic [1:0]    sew_i,
  input  logic [2:0]    mlen_lg_i,
  input  logic [1:0]    lmul_i,
  input  logic [CW-1:0] vl_i,
  input  logic [CW-1:0] vstart_i,
  input  logic [4:0]    rd_i,
  input  logic [4:0]    rs2_i,
  input  logic [4:0]    rm_i,
  output logic          illegal_o,
  output logic [CW-1:0] limit_o,
  output logic [CW-1:0] scan_end_o
);
  logic [CW-1:0] vlmax, cap;
  logic [5:0]    grp_end;
  logic          overlap;

  always_comb begin
    vlmax      = CW'(VLEN >> mlen_lg_i);
    cap        = CW'(VLEN >> (3 + sew_i));
    limit_o    = (vlmax < cap) ? vlmax : cap;
    scan_end_o = (vl_i < limit_o) ? vl_i : limit_o;
    grp_end    = {1'b0, rd_i} + (6'd1 << lmul_i);
    overlap    = ({1'b0, rm_i} >= {1'b0, rd_i}) && ({1'b0, rm_i} < grp_end);
    illegal_o  = (rd_i == rs2_i) || overlap || (vstart_i != '0);
  end
endmodule

// File: rtl/vcu_elem.sv
module vcu_elem #(
  parameter int unsigned VLEN = 128,
  parameter int unsigned CW   = 8
) (
  input  logic [VLEN-1:0] src_i,
  input  logic [VLEN-1:0] mask_i,
  input  logic [1:0]      sew_i,
  input  logic [2:0]      mlen_lg_i,
  input  logic [CW-1:0]   idx_i,
  output logic [63:0]     elem_o,
  output logic            bit_set_o
);
  logic [VLEN-1:0] src_sh, mask_sh;
  logic [31:0]     boff, moff;

  always_comb begin
    boff      = 32'(idx_i) << (3 + sew_i);
    moff      = 32'(idx_i) << mlen_lg_i;
    src_sh    = src_i >> boff;
    mask_sh   = mask_i >> moff;
    bit_set_o = mask_sh[0];
    case (sew_i)
      2'd0:    elem_o = {56'd0, src_sh[7:0]};
      2'd1:    elem_o = {48'd0, src_sh[15:0]};
      2'd2:    elem_o = {32'd0, src_sh[31:0]};
      default: elem_o = src_sh[63:0];
    endcase
  end
endmodule

// File: rtl/vcu_dest.sv
module vcu_dest #(
  parameter int unsigned VLEN = 128,
  parameter int unsigned CW   = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we_i,
  input  logic [1:0]      sew_i,
  input  logic [CW-1:0]   slot_i,
  input  logic [63:0]     wdata_i,
  output logic [VLEN-1:0] dest_o
);
  logic [VLEN-1:0] dest_q, wide, wmask;
  logic [63:0]     lane_mask;
  logic [31:0]     off;

  always_comb begin
    case (sew_i)
      2'd0:    lane_mask = 64'h0000_0000_0000_00FF;
      2'd1:    lane_mask = 64'h0000_0000_0000_FFFF;
      2'd2:    lane_mask = 64'h0000_0000_FFFF_FFFF;
      default: lane_mask = '1;
    endcase
    off   = 32'(slot_i) << (3 + sew_i);
    wide  = VLEN'(wdata_i) << off;
    wmask = VLEN'(lane_mask) << off;
  end

  always_ff @(posedge clk) begin
    if (rst) dest_q <= '0;
    else if (we_i) dest_q <= (dest_q & ~wmask) | (wide & wmask);
  end

  assign dest_o = dest_q;

  // R5: every write lands fully inside the register
  p_slot_in_reg_r5: assert property (@(posedge clk) disable iff (rst)
    we_i |-> ((32'(slot_i) + 32'd1) << (3 + sew_i)) <= VLEN);
endmodule

// File: rtl/vec_compress_unit.sv
module vec_compress_unit
  import vcu_pkg::*;
#(
  parameter int unsigned VLEN  = 128,
  parameter int unsigned CNT_W = $clog2(VLEN) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [1:0]       sew_i,
  input  logic [2:0]       mlen_lg_i,
  input  logic [1:0]       lmul_i,
  input  logic [CNT_W-1:0] vl_i,
  input  logic [CNT_W-1:0] vstart_i,
  input  logic [4:0]       rd_i,
  input  logic [4:0]       rs2_i,
  input  logic [4:0]       rm_i,
  input  logic [VLEN-1:0]  src_i,
  input  logic [VLEN-1:0]  mask_i,
  output logic [VLEN-1:0]  dest_o,
  output logic             done_o,
  output logic             err_o,
  output logic [CNT_W-1:0] count_o,
  output logic             vstart_clr_o
);
  vcu_state_e       state_q;
  logic [1:0]       sew_q;
  logic [2:0]       mlen_q;
  logic [CNT_W-1:0] limit_q, scan_end_q, idx_q, wp_q, cnt_q;
  logic [VLEN-1:0]  src_q, mask_q;
  logic             done_q, err_q, clr_q;

  logic             illegal;
  logic [CNT_W-1:0] limit_c, scan_end_c;
  logic [63:0]      elem, wdata;
  logic             bit_set, we;

  vcu_check #(.VLEN(VLEN), .CW(CNT_W)) u_check (
    .sew_i(sew_i), .mlen_lg_i(mlen_lg_i), .lmul_i(lmul_i), .vl_i(vl_i),
    .vstart_i(vstart_i), .rd_i(rd_i), .rs2_i(rs2_i), .rm_i(rm_i),
    .illegal_o(illegal), .limit_o(limit_c), .scan_end_o(scan_end_c));

  vcu_elem #(.VLEN(VLEN), .CW(CNT_W)) u_elem (
    .src_i(src_q), .mask_i(mask_q), .sew_i(sew_q), .mlen_lg_i(mlen_q),
    .idx_i(idx_q), .elem_o(elem), .bit_set_o(bit_set));

  always_comb begin
    we    = ((state_q == ST_SCAN) && bit_set) ||
            ((state_q == ST_TAIL) && (wp_q != limit_q));
    wdata = (state_q == ST_SCAN) ? elem : 64'd0;
  end

  vcu_dest #(.VLEN(VLEN), .CW(CNT_W)) u_dest (
    .clk(clk), .rst(rst), .we_i(we), .sew_i(sew_q), .slot_i(wp_q),
    .wdata_i(wdata), .dest_o(dest_o));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      sew_q <= '0; mlen_q <= '0; limit_q <= '0; scan_end_q <= '0;
      idx_q <= '0; wp_q <= '0; cnt_q <= '0;
      src_q <= '0; mask_q <= '0;
      done_q <= 1'b0; err_q <= 1'b0; clr_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      clr_q  <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_i) begin
          cnt_q <= '0;
          if (illegal) begin
            done_q <= 1'b1;
            err_q  <= 1'b1;
          end else begin
            sew_q <= sew_i; mlen_q <= mlen_lg_i;
            limit_q <= limit_c; scan_end_q <= scan_end_c;
            src_q <= src_i; mask_q <= mask_i;
            idx_q <= '0; wp_q <= '0;
            state_q <= (scan_end_c == '0) ? ST_TAIL : ST_SCAN;
          end
        end
        ST_SCAN: begin
          idx_q <= idx_q + CNT_W'(1);
          if (bit_set) wp_q <= wp_q + CNT_W'(1);
          if (idx_q == scan_end_q - CNT_W'(1)) begin
            cnt_q   <= wp_q + CNT_W'(bit_set);
            state_q <= ST_TAIL;
          end
        end
        ST_TAIL: begin
          if (wp_q == limit_q) begin
            done_q  <= 1'b1;
            clr_q   <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            wp_q <= wp_q + CNT_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o       = done_q;
  assign err_o        = err_q;
  assign count_o      = cnt_q;
  assign vstart_clr_o = clr_q;

  // R9: a rejected operation leaves the destination as it was
  p_illegal_keeps_dest_r9: assert property (@(posedge clk) disable iff (rst)
    (done_o && err_o) |-> (dest_o == $past(dest_o)));
  // R9: start-index clear only accompanies a successful finish
  p_clear_on_success_r9: assert property (@(posedge clk) disable iff (rst)
    vstart_clr_o |-> (done_o && !err_o));
  // R11: packed count never exceeds the examined element count
  p_count_bound_r11: assert property (@(posedge clk) disable iff (rst)
    (done_o && !err_o) |-> (count_o <= scan_end_q));
  // R10: scanning advances exactly one element per cycle
  p_scan_step_r10: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_SCAN) && $past(state_q == ST_SCAN)) |-> (idx_q == $past(idx_q) + CNT_W'(1)));
  // R1: the write slot never runs ahead of the scan index
  p_pack_order_r1: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SCAN) |-> (wp_q <= idx_q));
endmodule

// File: tb/vec_compress_unit_tb_top.sv
`timescale 1ns/1ps
module vec_compress_unit_tb_top;
  localparam int unsigned VLEN = 128;
  localparam int unsigned CW   = $clog2(VLEN) + 1;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [1:0] sew = '0, lmul = '0;
  logic [2:0] mlen = '0;
  logic [CW-1:0] vl = '0, vstart = '0;
  logic [4:0] rd = '0, rs2 = '0, rm = '0;
  logic [VLEN-1:0] src = '0, mask = '0, dest;
  logic done, err, clr;
  logic [CW-1:0] count;

  always #10 clk = ~clk;

  vec_compress_unit #(.VLEN(VLEN)) dut_i (
    .clk(clk), .rst(rst), .start_i(start), .sew_i(sew), .mlen_lg_i(mlen),
    .lmul_i(lmul), .vl_i(vl), .vstart_i(vstart), .rd_i(rd), .rs2_i(rs2),
    .rm_i(rm), .src_i(src), .mask_i(mask), .dest_o(dest), .done_o(done),
    .err_o(err), .count_o(count), .vstart_clr_o(clr));

  typedef struct {
    logic [VLEN-1:0] dest;
    int cnt; bit err; bit clr; int lat; int start_cyc; string tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0, cyc = 0;
  logic [VLEN-1:0] model = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string tag, string what, logic [VLEN-1:0] act, logic [VLEN-1:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  // monitor: pop and compare on each done
  always @(negedge clk) begin
    if (!rst && done) begin
      if (q.size() == 0) chk(1'b0, "R9", "unexpected done", 1, 0);
      else begin
        exp_t e;
        e = q.pop_front();
        chk(dest === e.dest, e.tag, "dest", dest, e.dest);
        chk(int'(count) == e.cnt, "R11", "count", VLEN'(count), VLEN'(e.cnt));
        chk(err === e.err, e.tag, "err", VLEN'(err), VLEN'(e.err));
        chk(clr === e.clr, "R9", "vstart_clr", VLEN'(clr), VLEN'(e.clr));
        chk(cyc - e.start_cyc == e.lat, "R10", "latency", VLEN'(cyc - e.start_cyc), VLEN'(e.lat));
      end
    end
  end

  task automatic run_op(string tag, int s, int ml, int lm, int v, int vs,
                        int d, int r2, int m, logic [VLEN-1:0] sv, logic [VLEN-1:0] mv);
    exp_t e;
    int ebits, cap, vmax, lim, n, k;
    bit ill;
    ebits = 8 << s; cap = VLEN / ebits; vmax = VLEN >> ml;
    lim = (vmax < cap) ? vmax : cap;
    n = (v < lim) ? v : lim;
    ill = (d == r2) || (m >= d && m < d + (1 << lm)) || (vs != 0);
    e.tag = tag; e.start_cyc = cyc + 1;
    if (ill) begin
      e.dest = model; e.cnt = 0; e.err = 1; e.clr = 0; e.lat = 0;
    end else begin
      e.dest = model; k = 0;
      for (int i = 0; i < n; i++)
        if (mv[i << ml]) begin
          for (int b = 0; b < ebits; b++) e.dest[k*ebits + b] = sv[i*ebits + b];
          k++;
        end
      for (int j = k; j < lim; j++)
        for (int b = 0; b < ebits; b++) e.dest[j*ebits + b] = 1'b0;
      e.cnt = k; e.err = 0; e.clr = 1; e.lat = n + (lim - k) + 1;
    end
    model = e.dest;
    q.push_back(e);
    sew = 2'(s); mlen = 3'(ml); lmul = 2'(lm); vl = CW'(v); vstart = CW'(vs);
    rd = 5'(d); rs2 = 5'(r2); rm = 5'(m); src = sv; mask = mv;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [VLEN-1:0] pat;
    pat = 128'h8877_6655_4433_2211_F0E1_D2C3_B4A5_9687;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(dest == '0, "R9", "reset dest", dest, '0);
    chk(!done && !err && !clr, "R9", "reset flags", VLEN'({done, err, clr}), '0);
    // R1 R5: bytes, stride 8, alternating enables
    run_op("R1", 0, 3, 0, 16, 0, 2, 3, 1, pat, 128'h0001_0000_0001_0001_0000_0100_0001_0101);
    // R5: all bytes packed, fills register
    run_op("R5", 0, 3, 0, 16, 0, 2, 3, 1, pat, {16{8'h01}});
    // R4: stride 16 bytes -> limit 8, upper slots kept
    run_op("R4", 0, 4, 0, 8, 0, 2, 3, 1, ~pat, 128'h0001_0000_0001_0000_0000_0001_0000_0001);
    // R3 R5: halfwords, vl 5 of 8
    run_op("R3", 1, 4, 0, 5, 0, 4, 5, 9, pat, {8{16'h0001}});
    // R5: words, nothing enabled
    run_op("R5", 2, 5, 0, 4, 0, 4, 5, 9, pat, '0);
    // R5: doublewords, only element 1
    run_op("R5", 3, 6, 0, 2, 0, 4, 5, 9, pat, 128'h1 << 64);
    // R2: unit stride, bits at other positions ignored
    run_op("R2", 0, 0, 0, 16, 0, 6, 7, 8, pat, 128'hFFFF_0000_FFFF_0000_FFFF_0000_FFFF_A5A5);
    // R2: stride 8, set only off-stride bits
    run_op("R2", 0, 3, 0, 16, 0, 6, 7, 8, pat, {16{8'hFE}});
    // R3: vl 0 and vl clamped
    run_op("R3", 1, 4, 0, 0, 0, 6, 7, 8, pat, '1);
    run_op("R3", 0, 3, 0, 200, 0, 6, 7, 8, pat, {16{8'h01}});
    // R6 R7 R8: illegal forms leave dest
    run_op("R6", 0, 3, 0, 16, 0, 3, 3, 9, ~pat, '1);
    run_op("R7", 0, 3, 2, 16, 0, 4, 12, 7, ~pat, '1);
    run_op("R7", 0, 3, 0, 16, 0, 4, 12, 4, ~pat, '1);
    run_op("R7", 1, 4, 2, 8, 0, 4, 12, 8, ~pat, {8{16'h0001}});
    run_op("R8", 0, 3, 0, 16, 3, 4, 12, 20, ~pat, '1);
    // R12: register 0 as destination
    run_op("R12", 2, 5, 0, 4, 0, 0, 2, 1, ~pat, 128'h1_0000_0000_0000_0001);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule